// File: doc/BRIEF.md
# Packet framing error checker

This block sits between a packet receive interface and a set of packet buffers. Each incoming word carries a start marker, an end marker, an 8-bit port address and a data payload. The block keeps one open-packet bit for each port and repairs framing violations as it goes. A start on a port whose packet is still open marks the earlier packet as abnormally closed. A data word on a port with no open packet gets a start marker forced onto it. Each repair raises a one-cycle error pulse for the buffer the word is headed to.

The block also watches the full indication of each target buffer. A word aimed at a full buffer is dropped, and the block raises an overflow pulse for that buffer. A static check enable, captured only while reset is held, turns the framing detection and repair on or off for every port at once. Two buffer arrangements are built from one parameter. In the first, each port has a buffer of its own and its own flags. In the second, all ports share one buffer, and an 8-bit error address output names the port that caused a framing error.

Top module: `pfc_top`

## Requirements
- R1: The check enable is captured only while `rst` is high; changing `cfgCheckEn` after reset has no effect until the next reset.
- R2: With checking disabled, every accepted word passes through unchanged (`outSop` equals the input start bit, `outAbort` is 0), no framing flag is raised, and no port state is kept.
- R3: An accepted word (valid, address below `NUM_PORTS`, target buffer not full) appears on the output one clock later with the same address, data and end bit and with `outValid` high. When no word is forwarded, `outValid` is 0.
- R4: With checking enabled, a word without a start bit on a port with no open packet pulses that buffer's bit of `errMissSop` and leaves with `outSop` forced to 1.
- R5: With checking enabled, a word with a start bit on a port that already has an open packet pulses that buffer's bit of `errMissEop` and leaves with `outSop`=1 and `outAbort`=1. `outAbort`=1 means that the previous packet of that port ended abnormally.
- R6: Per-port state: after any checked word the port is open exactly when that word had no end bit. A single-word packet (start and end together) leaves the port closed, and ports do not affect one another.
- R7: A valid in-range word whose target buffer's `bufFull` bit is high is dropped (`outValid` 0) and pulses that buffer's bit of `errOvfl` one clock later. The port's framing state is still updated.
- R8: With `SHARED`=0, buffer index equals port number and `errAddr` stays 0. With `SHARED`=1, every flag uses bit 0 and `errAddr` holds the port number in the cycle a framing flag is high, and 0 otherwise.
- R9: A word whose address is `NUM_PORTS` or greater is discarded: there is no output word, no flag, and no change of port state.
- R10: During and right after reset, all outputs are 0 and every port is closed.
- R11: All flags are single-cycle pulses tied to one input word; they are 0 in a cycle that follows no valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgCheckEn | input | 1 | Static framing check enable, captured during reset |
| inValid | input | 1 | Input word valid |
| inSop | input | 1 | Input start-of-packet marker |
| inEop | input | 1 | Input end-of-packet marker |
| inAddr | input | 8 | Input port address |
| inData | input | DATA_W | Input payload |
| bufFull | input | NUM_BUF | Full indication per target buffer |
| outValid | output | 1 | Output word valid |
| outSop | output | 1 | Output start marker (possibly forced) |
| outEop | output | 1 | Output end marker |
| outAbort | output | 1 | Previous packet of this port closed abnormally |
| outAddr | output | 8 | Output port address |
| outData | output | DATA_W | Output payload |
| errMissSop | output | NUM_BUF | Missing-start pulse per buffer |
| errMissEop | output | NUM_BUF | Missing-end pulse per buffer |
| errOvfl | output | NUM_BUF | Overflow pulse per buffer |
| errAddr | output | 8 | Port of the framing error (shared mode only) |

## Verification
The assertions assume that `rst` is held for at least one clock, so that the check enable is captured, and that `inValid` is low during reset. They also assume that `bufFull` reflects the state of the buffer at the input clock. The stimulus drives every input on the falling edge, keeps `inValid` low while reset is held, and changes `cfgCheckEn` only to show that a change after reset has no effect. The sweeps mix in-range and out-of-range addresses, all start and end combinations, and full bits on both the target buffer and other buffers. Each swept word is checked against an open-bit model kept in the bench.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  // Decisions the control hands to the datapath for one input word.
  typedef struct packed {
    logic fwd;       // word goes to its buffer
    logic ovfl;      // word dropped, buffer full
    logic missSop;   // no open packet, start forced
    logic missEop;   // start on open packet, previous closed abnormally
    logic sopOut;    // start marker as emitted
  } pfc_strobes_t;

endpackage

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int SHARED    = 0,
  parameter int NUM_BUF   = 4,
  parameter int IDX_W     = 2,
  parameter int BUF_W     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgCheckEn,
  input  logic               inValid,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [7:0]         inAddr,
  input  logic [NUM_BUF-1:0] bufFull,
  output pfc_strobes_t       strobes,
  output logic [BUF_W-1:0]   bufIdx,
  output logic               checkEnQ
);

  logic [NUM_PORTS-1:0] portOpen;
  logic [IDX_W-1:0]     portIdx;
  logic                 inRange;
  logic                 accept;
  logic                 track;
  logic                 isOpen;
  logic                 tgtFull;

  assign inRange = (int'(inAddr) < NUM_PORTS);
  assign portIdx = inAddr[IDX_W-1:0];
  assign accept  = inValid && inRange;
  assign track   = accept && checkEnQ;
  assign isOpen  = portOpen[portIdx];

  generate
    if (SHARED != 0) begin : gSharedIdx
      assign bufIdx = '0;
    end else begin : gPortIdx
      assign bufIdx = BUF_W'(portIdx);
    end
  endgenerate

  assign tgtFull = bufFull[bufIdx];

  always_comb begin
    strobes         = '0;
    strobes.fwd     = accept && !tgtFull;
    strobes.ovfl    = accept && tgtFull;
    strobes.missEop = track && inSop && isOpen;
    strobes.missSop = track && !inSop && !isOpen;
    strobes.sopOut  = inSop || strobes.missSop;
  end

  // Enable is captured while reset is held; port state follows checked words.
  always_ff @(posedge clk) begin
    if (rst) begin
      checkEnQ <= cfgCheckEn;
      portOpen <= '0;
    end else if (track) begin
      portOpen[portIdx] <= !inEop;
    end
  end

endmodule

// File: rtl/pfc_datapath.sv
module pfc_datapath
  import pfc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHARED  = 0,
  parameter int NUM_BUF = 4,
  parameter int BUF_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  pfc_strobes_t       strobes,
  input  logic [BUF_W-1:0]   bufIdx,
  input  logic               inEop,
  input  logic [7:0]         inAddr,
  input  logic [DATA_W-1:0]  inData,
  output logic               outValid,
  output logic               outSop,
  output logic               outEop,
  output logic               outAbort,
  output logic [7:0]         outAddr,
  output logic [DATA_W-1:0]  outData,
  output logic [NUM_BUF-1:0] errMissSop,
  output logic [NUM_BUF-1:0] errMissEop,
  output logic [NUM_BUF-1:0] errOvfl,
  output logic [7:0]         errAddr
);

  logic [NUM_BUF-1:0] bufSel;
  logic [7:0]         errAddrNext;

  always_comb begin
    bufSel = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (BUF_W'(b) == bufIdx) bufSel[b] = 1'b1;
    end
  end

  generate
    if (SHARED != 0) begin : gQualAddr
      assign errAddrNext = (strobes.missSop || strobes.missEop) ? inAddr : 8'd0;
    end else begin : gNoQualAddr
      assign errAddrNext = 8'd0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outSop     <= 1'b0;
      outEop     <= 1'b0;
      outAbort   <= 1'b0;
      outAddr    <= '0;
      outData    <= '0;
      errMissSop <= '0;
      errMissEop <= '0;
      errOvfl    <= '0;
      errAddr    <= '0;
    end else begin
      outValid   <= strobes.fwd;
      outSop     <= strobes.fwd && strobes.sopOut;
      outEop     <= strobes.fwd && inEop;
      outAbort   <= strobes.fwd && strobes.missEop;
      outAddr    <= strobes.fwd ? inAddr : 8'd0;
      outData    <= strobes.fwd ? inData : '0;
      errMissSop <= strobes.missSop ? bufSel : '0;
      errMissEop <= strobes.missEop ? bufSel : '0;
      errOvfl    <= strobes.ovfl ? bufSel : '0;
      errAddr    <= errAddrNext;
    end
  end

endmodule

// File: rtl/pfc_top.sv
module pfc_top
  import pfc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16,
  parameter int SHARED    = 0,
  localparam int NUM_BUF  = (SHARED != 0) ? 1 : NUM_PORTS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgCheckEn,
  input  logic               inValid,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [7:0]         inAddr,
  input  logic [DATA_W-1:0]  inData,
  input  logic [NUM_BUF-1:0] bufFull,
  output logic               outValid,
  output logic               outSop,
  output logic               outEop,
  output logic               outAbort,
  output logic [7:0]         outAddr,
  output logic [DATA_W-1:0]  outData,
  output logic [NUM_BUF-1:0] errMissSop,
  output logic [NUM_BUF-1:0] errMissEop,
  output logic [NUM_BUF-1:0] errOvfl,
  output logic [7:0]         errAddr
);

  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int BUF_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;

  pfc_strobes_t     strobes;
  logic [BUF_W-1:0] bufIdx;
  logic             checkEnQ;

  pfc_ctrl #(
    .NUM_PORTS(NUM_PORTS), .SHARED(SHARED), .NUM_BUF(NUM_BUF),
    .IDX_W(IDX_W), .BUF_W(BUF_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .cfgCheckEn(cfgCheckEn),
    .inValid(inValid), .inSop(inSop), .inEop(inEop), .inAddr(inAddr),
    .bufFull(bufFull), .strobes(strobes), .bufIdx(bufIdx), .checkEnQ(checkEnQ)
  );

  pfc_datapath #(
    .DATA_W(DATA_W), .SHARED(SHARED), .NUM_BUF(NUM_BUF), .BUF_W(BUF_W)
  ) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .bufIdx(bufIdx),
    .inEop(inEop), .inAddr(inAddr), .inData(inData),
    .outValid(outValid), .outSop(outSop), .outEop(outEop), .outAbort(outAbort),
    .outAddr(outAddr), .outData(outData),
    .errMissSop(errMissSop), .errMissEop(errMissEop), .errOvfl(errOvfl),
    .errAddr(errAddr)
  );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int NUM_BUF = 4,
  parameter int SHARED  = 0
) (
  input logic               clk,
  input logic               rst,
  input logic               checkEnQ,
  input logic               inValid,
  input logic               outValid,
  input logic               outSop,
  input logic               outAbort,
  input logic [NUM_BUF-1:0] errMissSop,
  input logic [NUM_BUF-1:0] errMissEop,
  input logic [NUM_BUF-1:0] errOvfl,
  input logic [7:0]         errAddr
);

  assert_static_en_R1: assert property (@(posedge clk) disable iff (rst)
    $stable(checkEnQ));

  assert_flags_need_check_R2: assert property (@(posedge clk) disable iff (rst)
    ((|errMissSop) || (|errMissEop)) |-> checkEnQ);

  assert_out_needs_in_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));

  assert_force_sop_R4: assert property (@(posedge clk) disable iff (rst)
    ((|errMissSop) && !(|errOvfl)) |-> (outValid && outSop));

  assert_abort_flag_R5: assert property (@(posedge clk) disable iff (rst)
    ((|errMissEop) && !(|errOvfl)) |-> (outValid && outSop && outAbort));

  assert_abort_cause_R5: assert property (@(posedge clk) disable iff (rst)
    outAbort |-> (|errMissEop));

  assert_sop_eop_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !((|errMissSop) && (|errMissEop)));

  assert_drop_on_full_R7: assert property (@(posedge clk) disable iff (rst)
    (|errOvfl) |-> !outValid);

  assert_one_buffer_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(errMissSop) && $onehot0(errMissEop) && $onehot0(errOvfl));

  assert_addr_qual_R8: assert property (@(posedge clk) disable iff (rst)
    (errAddr != 8'd0) |-> ((SHARED != 0) && ((|errMissSop) || (|errMissEop))));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid) |-> ((errMissSop == '0) && (errMissEop == '0) && (errOvfl == '0)));

endmodule

bind pfc_top pfc_checker #(.NUM_BUF(NUM_BUF), .SHARED(SHARED)) uChk (
  .clk(clk), .rst(rst), .checkEnQ(checkEnQ), .inValid(inValid),
  .outValid(outValid), .outSop(outSop), .outAbort(outAbort),
  .errMissSop(errMissSop), .errMissEop(errMissEop), .errOvfl(errOvfl),
  .errAddr(errAddr)
);

// File: tb/tb_pfc_top.sv
`timescale 1ns/1ps
module tb_pfc_top;

  localparam int NP = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgCheckEn = 1'b1;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [7:0] inAddr = '0;
  logic [DW-1:0] inData = '0;
  logic [NP-1:0] bufFull = '0;
  logic [0:0] bufFullS = '0;

  logic outValid, outSop, outEop, outAbort;
  logic [7:0] outAddr, errAddr;
  logic [DW-1:0] outData;
  logic [NP-1:0] errMissSop, errMissEop, errOvfl;

  logic outValidS, outSopS, outEopS, outAbortS;
  logic [7:0] outAddrS, errAddrS;
  logic [DW-1:0] outDataS;
  logic [0:0] errMissSopS, errMissEopS, errOvflS;

  int checks = 0;
  int fails = 0;
  bit model [NP];
  bit modeEn = 1'b1;
  int seed = 7;

  always #10 clk = ~clk;

  pfc_top #(.NUM_PORTS(NP), .DATA_W(DW), .SHARED(0)) dut (
    .clk(clk), .rst(rst), .cfgCheckEn(cfgCheckEn), .inValid(inValid),
    .inSop(inSop), .inEop(inEop), .inAddr(inAddr), .inData(inData),
    .bufFull(bufFull), .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outAbort(outAbort), .outAddr(outAddr), .outData(outData),
    .errMissSop(errMissSop), .errMissEop(errMissEop), .errOvfl(errOvfl),
    .errAddr(errAddr));

  pfc_top #(.NUM_PORTS(NP), .DATA_W(DW), .SHARED(1)) dutShared (
    .clk(clk), .rst(rst), .cfgCheckEn(cfgCheckEn), .inValid(inValid),
    .inSop(inSop), .inEop(inEop), .inAddr(inAddr), .inData(inData),
    .bufFull(bufFullS), .outValid(outValidS), .outSop(outSopS), .outEop(outEopS),
    .outAbort(outAbortS), .outAddr(outAddrS), .outData(outDataS),
    .errMissSop(errMissSopS), .errMissEop(errMissEopS), .errOvfl(errOvflS),
    .errAddr(errAddrS));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic doReset(bit en);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; cfgCheckEn = en;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < NP; p++) model[p] = 1'b0;
    modeEn = en;
    @(posedge clk); #5;
    chk("R10", "outValid after reset", int'(outValid | outValidS), 0);
    chk("R10", "flags after reset",
        int'({errMissSop, errMissEop, errOvfl, errMissSopS, errMissEopS, errOvflS}), 0);
    chk("R10", "errAddr after reset", int'(errAddr | errAddrS), 0);
  endtask

  task automatic idleCycle();
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); #5;
    chk("R11", "flags clear after idle",
        int'({errMissSop, errMissEop, errOvfl, errMissSopS, errMissEopS, errOvflS}), 0);
    chk("R3", "outValid low after idle", int'(outValid | outValidS), 0);
  endtask

  task automatic sendWord(bit sop, bit eop, logic [7:0] addr, logic [DW-1:0] data,
                          bit full, logic [NP-1:0] otherFull);
    bit inR, open, mS, mE;
    int oneHot;
    string fr;
    inR = (int'(addr) < NP);
    open = inR ? model[addr[1:0]] : 1'b0;
    mE = modeEn && inR && sop && open;
    mS = modeEn && inR && !sop && !open;
    oneHot = inR ? int'(4'b0001 << addr[1:0]) : 0;
    fr = modeEn ? "R4" : "R2";
    @(negedge clk);
    inValid = 1'b1; inSop = sop; inEop = eop; inAddr = addr; inData = data;
    bufFull = otherFull;
    if (inR) bufFull[addr[1:0]] = full;
    bufFullS = full;
    @(posedge clk); #5;
    chk(inR ? "R3" : "R9", "outValid", int'(outValid), int'(inR && !full));
    if (inR && !full) begin
      chk(fr, "outSop", int'(outSop), int'(sop || mS));
      chk("R5", "outAbort", int'(outAbort), int'(mE));
      chk("R3", "outEop", int'(outEop), int'(eop));
      chk("R3", "outAddr", int'(outAddr), int'(addr));
      chk("R3", "outData", int'(outData), int'(data));
      chk("R8", "shared outSop", int'(outSopS), int'(sop || mS));
      chk("R8", "shared outData", int'(outDataS), int'(data));
    end
    chk(fr, "errMissSop", int'(errMissSop), mS ? oneHot : 0);
    chk(modeEn ? "R5" : "R2", "errMissEop", int'(errMissEop), mE ? oneHot : 0);
    chk("R7", "errOvfl", int'(errOvfl), (inR && full) ? oneHot : 0);
    chk("R8", "errAddr per-port", int'(errAddr), 0);
    chk("R8", "shared outValid", int'(outValidS), int'(inR && !full));
    chk("R8", "shared errMissSop", int'(errMissSopS), int'(mS));
    chk("R8", "shared errMissEop", int'(errMissEopS), int'(mE));
    chk("R8", "shared errOvfl", int'(errOvflS), int'(inR && full));
    chk("R8", "shared errAddr", int'(errAddrS), (mS || mE) ? int'(addr) : 0);
    if (modeEn && inR) model[addr[1:0]] = !eop;  // R6 model
  endtask

  function automatic int nextRand();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return seed >>> 8;
  endfunction

  task automatic sweep(int count);
    for (int i = 0; i < count; i++) begin
      int r;
      logic [7:0] a;
      r = nextRand();
      case (r % 6)
        4: a = 8'd4;
        5: a = 8'd250;
        default: a = 8'(r % 6);
      endcase
      sendWord(r[3], r[4], a, DW'(r >> 5), (r[9:7] == 3'b000), NP'(r >> 10));
    end
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    doReset(1'b1);
    // Directed framing cases.
    sendWord(1, 0, 8'd0, 16'h1111, 0, '0);
    sendWord(0, 0, 8'd0, 16'h2222, 0, '0);
    sendWord(1, 0, 8'd0, 16'h3333, 0, '0);          // missing end on port 0
    chk("R5", "port0 abort", int'(outAbort && errMissEop[0]), 1);
    sendWord(0, 1, 8'd1, 16'h4444, 0, '0);          // missing start on port 1
    chk("R4", "port1 forced start", int'(outSop && errMissSop[1]), 1);
    sendWord(1, 1, 8'd2, 16'h5555, 0, '0);          // single-word packet
    sendWord(0, 0, 8'd2, 16'h6666, 0, '0);
    chk("R6", "single word leaves port closed", int'(errMissSop[2]), 1);
    sendWord(0, 1, 8'd0, 16'h7777, 0, '0);
    chk("R6", "port0 unaffected by port2", int'(errMissSop), 0);
    idleCycle();
    sendWord(1, 0, 8'd3, 16'h8888, 1, '0);          // overflow, state still opens
    chk("R7", "overflow drop", int'(errOvfl[3] && !outValid), 1);
    sendWord(1, 0, 8'd3, 16'h9999, 0, '0);
    chk("R7", "state updated on dropped word", int'(errMissEop[3]), 1);
    sendWord(0, 0, 8'd9, 16'haaaa, 0, '0);
    chk("R9", "out-of-range discarded", int'(outValid | errMissSop[0] | errAddrS), 0);
    sendWord(1, 1, 8'd3, 16'hbbbb, 0, '0);
    idleCycle();
    // Change of enable after reset must not matter.
    @(negedge clk); cfgCheckEn = 1'b0;
    sendWord(0, 0, 8'd1, 16'hcccc, 0, '0);
    chk("R1", "enable held after reset", int'(errMissSop[1]), 1);
    sweep(600);
    idleCycle();
    // Checking disabled: pass-through.
    doReset(1'b0);
    @(negedge clk); cfgCheckEn = 1'b1;
    sendWord(0, 0, 8'd2, 16'h0f0f, 0, '0);
    chk("R1", "late enable ignored", int'(errMissSop[2] | outSop), 0);
    sweep(300);
    idleCycle();
    // Back to checking with a fresh reset.
    doReset(1'b1);
    sweep(400);
    idleCycle();
    finishRun();
  end

endmodule